// File: doc/BRIEF.md
# Serial EEPROM Write Front End

This block is the write side of a byte-addressed serial memory slave on a two-wire bus. A separate bit engine turns the bus into events: a start, a stop, a completed byte, and a flag that says bits of an unfinished byte are being shifted in. The front end decodes the addressing byte, builds a 17-bit address pointer from a block bit and two address bytes, and puts each data byte into a 64-slot page buffer indexed by the six low pointer bits. It also gives the acknowledge decision for every byte.

On a clean stop, and only if the write-protect input is low at that moment, a write-cycle sequencer scans the page buffer. It issues one array write per filled slot to a simple synchronous memory port. The sequencer keeps busy high for the whole scan, and during that time the slave refuses its own addressing byte, so a master can poll for completion.

Top module: `eewr_frontend`

## Requirements
- R1: The first byte after a start is decoded as bits [7:4] fixed code 4'b1010, bit [3] block bit, bits [2:1] chip select, bit [0] direction. It is acknowledged (ack_o = 1 after the byte) only when the code matches, the chip select equals chip_sel_i and the direction bit is 0. Otherwise ack_o = 0, and every later byte is also refused until the next start.
- R2: After an accepted addressing byte, the high address byte, the low address byte and every data byte are acknowledged.
- R3: The pointer ptr_o is loaded as {block bit, high address byte, low address byte}.
- R4: Each data byte is stored at page slot ptr_o[5:0], and then only ptr_o[5:0] increments, wrapping from 63 to 0. Bits [16:6] never change during data.
- R5: When more than 64 data bytes arrive before a stop, the slot index wraps and later bytes replace earlier ones. The committed value of a slot is the last byte written to it.
- R6: A clean stop after at least one data byte sets busy_o on the stop's clock edge. Busy stays high for 64 cycles. During that time one array write is issued per filled slot, in ascending slot order, at address {ptr_o[16:6], slot}.
- R7: If wp_i is high when the stop is seen, the data bytes are still acknowledged, but no array write occurs and busy_o stays low. Changing wp_i after the stop has no effect on a commit that has started.
- R8: While busy_o is high, every byte is refused, including a matching addressing byte.
- R9: A stop seen while byte_partial is high aborts the transfer. Nothing is committed.
- R10: After a single-byte write, ptr_o holds the address after the byte just written.
- R11: After reset, ack_o, busy_o and wr_en_o are 0, and ptr_o is 0.
- R12: An addressing byte with direction bit 1 (a read) is refused by this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | One-cycle pulse: start seen on the bus |
| ev_stop | input | 1 | One-cycle pulse: stop seen on the bus |
| ev_byte | input | 1 | One-cycle pulse: a full byte is on rx_byte |
| rx_byte | input | 8 | Received byte, MSB first on the bus |
| byte_partial | input | 1 | Bit engine holds part of an unfinished byte |
| chip_sel_i | input | 2 | Strap value for the chip-select field |
| wp_i | input | 1 | Write protect, sampled with the stop |
| ack_o | output | 1 | Acknowledge decision for the last byte |
| busy_o | output | 1 | Write cycle in progress |
| ptr_o | output | 17 | Address pointer |
| wr_en_o | output | 1 | Array write strobe |
| wr_addr_o | output | 17 | Array write address |
| wr_data_o | output | 8 | Array write data |

## Verification
The bench aims at a page write that starts four slots below a page end, so it crosses the boundary. A design that carries into bit 6 would write the next page and leave ptr_o in the wrong page. A 66-byte burst shows whether the first two slots hold the last two bytes; a design with a wrong overwrite rule would commit stale data. A stop with write protect high, a stop during a partial byte, and an addressing poll during busy each catch a design that commits when it must not, or that acknowledges during its own write cycle.

// File: rtl/eewr_pkg.sv
package eewr_pkg;
  localparam int PTR_W = 17;
  localparam logic [3:0] CTRL_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_AHI,
    ST_ALO,
    ST_DATA,
    ST_SKIP
  } wr_state_e;
endpackage

// File: rtl/eewr_ctrl.sv
module eewr_ctrl
  import eewr_pkg::*;
#(
  parameter int PAGE_AW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_start,
  input  logic                 ev_stop,
  input  logic                 ev_byte,
  input  logic [7:0]           rx_byte,
  input  logic                 byte_partial,
  input  logic [1:0]           chip_sel_i,
  input  logic                 wp_i,
  input  logic                 busy_i,
  input  logic                 buf_any_i,
  output logic                 ack_o,
  output logic [PTR_W-1:0]     ptr_o,
  output logic                 buf_we_o,
  output logic                 buf_clr_o,
  output logic [PAGE_AW-1:0]   buf_idx_o,
  output logic                 commit_o
);
  wr_state_e          state_q, state_d;
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic               ack_q, ack_d;
  logic               addr_hit;
  logic [PAGE_AW-1:0] idx_inc;

  assign addr_hit = (rx_byte[7:4] == CTRL_CODE) && (rx_byte[2:1] == chip_sel_i)
                    && !rx_byte[0] && !busy_i;
  assign idx_inc  = ptr_q[PAGE_AW-1:0] + 1'b1;

  always_comb begin
    state_d   = state_q;
    ptr_d     = ptr_q;
    ack_d     = ack_q;
    buf_we_o  = 1'b0;
    buf_clr_o = 1'b0;
    commit_o  = 1'b0;
    if (ev_start) begin
      state_d   = ST_CTRL;
      ack_d     = 1'b0;
      buf_clr_o = !busy_i;
    end else if (ev_stop) begin
      state_d = ST_IDLE;
      ack_d   = 1'b0;
      commit_o = (state_q == ST_DATA) && !byte_partial && buf_any_i
                 && !wp_i && !busy_i;
    end else if (ev_byte) begin
      unique case (state_q)
        ST_CTRL: begin
          ack_d = addr_hit;
          if (addr_hit) begin
            ptr_d   = {rx_byte[3], ptr_q[PTR_W-2:0]};
            state_d = ST_AHI;
          end else begin
            state_d = ST_SKIP;
          end
        end
        ST_AHI: begin
          ack_d       = 1'b1;
          ptr_d[15:8] = rx_byte;
          state_d     = ST_ALO;
        end
        ST_ALO: begin
          ack_d      = 1'b1;
          ptr_d[7:0] = rx_byte;
          state_d    = ST_DATA;
        end
        ST_DATA: begin
          ack_d    = 1'b1;
          buf_we_o = 1'b1;
          ptr_d    = {ptr_q[PTR_W-1:PAGE_AW], idx_inc};
        end
        default: ack_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      ack_q   <= ack_d;
    end
  end

  assign ack_o     = ack_q;
  assign ptr_o     = ptr_q;
  assign buf_idx_o = ptr_q[PAGE_AW-1:0];
endmodule

// File: rtl/eewr_pagebuf.sv
module eewr_pagebuf #(
  parameter int PAGE_AW = 6,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic               clr,
  input  logic [PAGE_AW-1:0] widx,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [PAGE_AW-1:0] ridx,
  output logic [DATA_W-1:0]  rdata,
  output logic               rvalid,
  output logic               any_valid
);
  localparam int PAGE_N = 1 << PAGE_AW;

  logic [DATA_W-1:0] slot_q [PAGE_N];
  logic [PAGE_N-1:0] slot_we;
  logic [PAGE_N-1:0] valid_q, valid_d;

  for (genvar i = 0; i < PAGE_N; i++) begin : g_slot_we
    assign slot_we[i] = we && (widx == PAGE_AW'(i));
  end

  always_comb begin
    if (clr) valid_d = '0;
    else     valid_d = valid_q | slot_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_N; i++) begin
      if (slot_we[i]) slot_q[i] <= wdata;
    end
  end

  assign rdata     = slot_q[ridx];
  assign rvalid    = valid_q[ridx];
  assign any_valid = |valid_q;
endmodule

// File: rtl/eewr_commit_seq.sv
module eewr_commit_seq #(
  parameter int PAGE_AW = 6,
  parameter int DATA_W  = 8,
  parameter int PTR_W   = 17
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit_i,
  input  logic [PTR_W-PAGE_AW-1:0] page_i,
  input  logic                     rd_valid_i,
  input  logic [DATA_W-1:0]        rd_data_i,
  output logic [PAGE_AW-1:0]       rd_idx_o,
  output logic                     busy_o,
  output logic                     wr_en_o,
  output logic [PTR_W-1:0]         wr_addr_o,
  output logic [DATA_W-1:0]        wr_data_o
);
  localparam int PG_W = PTR_W - PAGE_AW;
  localparam logic [PAGE_AW-1:0] IDX_LAST = {PAGE_AW{1'b1}};

  logic               busy_q, busy_d;
  logic [PAGE_AW-1:0] idx_q, idx_d;
  logic [PG_W-1:0]    page_q, page_d;
  logic               wen_q, wen_d;
  logic [PTR_W-1:0]   waddr_q;
  logic [DATA_W-1:0]  wdata_q;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    page_d = page_q;
    wen_d  = 1'b0;
    if (busy_q) begin
      wen_d = rd_valid_i;
      idx_d = idx_q + 1'b1;
      if (idx_q == IDX_LAST) busy_d = 1'b0;
    end else if (commit_i) begin
      busy_d = 1'b1;
      idx_d  = '0;
      page_d = page_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      page_q <= '0;
      wen_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      page_q <= page_d;
      wen_q  <= wen_d;
    end
  end

  always_ff @(posedge clk) begin
    if (busy_q) begin
      waddr_q <= {page_q, idx_q};
      wdata_q <= rd_data_i;
    end
  end

  assign rd_idx_o  = idx_q;
  assign busy_o    = busy_q;
  assign wr_en_o   = wen_q;
  assign wr_addr_o = waddr_q;
  assign wr_data_o = wdata_q;
endmodule

// File: rtl/eewr_frontend.sv
module eewr_frontend
  import eewr_pkg::*;
#(
  parameter int PAGE_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_byte,
  input  logic [7:0]        rx_byte,
  input  logic              byte_partial,
  input  logic [1:0]        chip_sel_i,
  input  logic              wp_i,
  output logic              ack_o,
  output logic              busy_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              wr_en_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic [7:0]        wr_data_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_core_n;
  logic               buf_we, buf_clr, buf_any, rd_valid, commit;
  logic [PAGE_AW-1:0] wr_idx, rd_idx;
  logic [7:0]         rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  eewr_ctrl #(.PAGE_AW(PAGE_AW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .ev_start     (ev_start),
    .ev_stop      (ev_stop),
    .ev_byte      (ev_byte),
    .rx_byte      (rx_byte),
    .byte_partial (byte_partial),
    .chip_sel_i   (chip_sel_i),
    .wp_i         (wp_i),
    .busy_i       (busy_o),
    .buf_any_i    (buf_any),
    .ack_o        (ack_o),
    .ptr_o        (ptr_o),
    .buf_we_o     (buf_we),
    .buf_clr_o    (buf_clr),
    .buf_idx_o    (wr_idx),
    .commit_o     (commit)
  );

  eewr_pagebuf #(.PAGE_AW(PAGE_AW), .DATA_W(8)) u_buf (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .we        (buf_we),
    .clr       (buf_clr),
    .widx      (wr_idx),
    .wdata     (rx_byte),
    .ridx      (rd_idx),
    .rdata     (rd_data),
    .rvalid    (rd_valid),
    .any_valid (buf_any)
  );

  eewr_commit_seq #(.PAGE_AW(PAGE_AW), .DATA_W(8), .PTR_W(PTR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .commit_i   (commit),
    .page_i     (ptr_o[PTR_W-1:PAGE_AW]),
    .rd_valid_i (rd_valid),
    .rd_data_i  (rd_data),
    .rd_idx_o   (rd_idx),
    .busy_o     (busy_o),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o)
  );
endmodule

// File: rtl/eewr_frontend_chk.sv
module eewr_frontend_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_byte,
  input logic        ev_stop,
  input logic        byte_partial,
  input logic        wp_i,
  input logic        ack_o,
  input logic        busy_o,
  input logic        wr_en_o,
  input logic [16:0] wr_addr_o
);
  // R2
  ack_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(ev_byte));

  // R8
  no_ack_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_byte && busy_o) |=> !ack_o);

  // R6
  write_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(busy_o));

  // R6
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && $past(wr_en_o)) |-> $stable(wr_addr_o[16:6]));

  // R7
  protect_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && wp_i && !busy_o) |=> !busy_o);

  // R9
  abort_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && byte_partial && !busy_o) |=> !busy_o);
endmodule

bind eewr_frontend eewr_frontend_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ev_byte      (ev_byte),
  .ev_stop      (ev_stop),
  .byte_partial (byte_partial),
  .wp_i         (wp_i),
  .ack_o        (ack_o),
  .busy_o       (busy_o),
  .wr_en_o      (wr_en_o),
  .wr_addr_o    (wr_addr_o)
);

// File: tb/eewr_frontend_tb.sv
module eewr_frontend_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_start = 1'b0, ev_stop = 1'b0, ev_byte = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        byte_partial = 1'b0;
  logic [1:0]  chip_sel_i = 2'b01;
  logic        wp_i = 1'b0;
  logic        ack_o, busy_o, wr_en_o;
  logic [16:0] ptr_o, wr_addr_o;
  logic [7:0]  wr_data_o;

  int total = 0;
  int bad = 0;
  logic [16:0] log_a[$];
  logic [7:0]  log_d[$];

  always #10 clk = ~clk;

  eewr_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_byte(ev_byte), .rx_byte(rx_byte), .byte_partial(byte_partial),
    .chip_sel_i(chip_sel_i), .wp_i(wp_i), .ack_o(ack_o), .busy_o(busy_o),
    .ptr_o(ptr_o), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  // simple array model: record each write
  always @(negedge clk) begin
    if (wr_en_o) begin
      log_a.push_back(wr_addr_o);
      log_d.push_back(wr_data_o);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic partial);
    @(negedge clk); ev_start = 1'b1; byte_partial = partial;
    @(negedge clk); ev_start = 1'b0; byte_partial = 1'b0;
  endtask

  task automatic do_stop(input logic wp, input logic partial);
    @(negedge clk); ev_stop = 1'b1; wp_i = wp; byte_partial = partial;
    @(negedge clk); ev_stop = 1'b0; byte_partial = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    @(negedge clk); ev_byte = 1'b1; rx_byte = b;
    @(negedge clk); ev_byte = 1'b0; ack = ack_o;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 200) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    check("R6 busy ends", {31'd0, busy_o}, 32'd0);
  endtask

  task automatic setup(input logic [7:0] ctl, input logic [7:0] hi, input logic [7:0] lo);
    logic a;
    do_start(1'b0);
    send(ctl, a); check("R1 addressing ack", {31'd0, a}, 32'd1);
    send(hi, a);  check("R2 high address ack", {31'd0, a}, 32'd1);
    send(lo, a);  check("R2 low address ack", {31'd0, a}, 32'd1);
  endtask

  task automatic t_reset();
    check("R11 ack", {31'd0, ack_o}, 32'd0);
    check("R11 busy", {31'd0, busy_o}, 32'd0);
    check("R11 wr_en", {31'd0, wr_en_o}, 32'd0);
    check("R11 ptr", {15'd0, ptr_o}, 32'd0);
  endtask

  task automatic t_byte_write();
    logic a;
    log_a.delete(); log_d.delete();
    setup(8'hA2, 8'h12, 8'h34);
    check("R3 ptr load", {15'd0, ptr_o}, 32'h01234);
    send(8'h5A, a); check("R2 data ack", {31'd0, a}, 32'd1);
    do_stop(1'b0, 1'b0);
    check("R6 busy after stop", {31'd0, busy_o}, 32'd1);
    check("R10 ptr next", {15'd0, ptr_o}, 32'h01235);
    wait_idle();
    check("R6 write count", log_a.size(), 32'd1);
    if (log_a.size() == 1) begin
      check("R6 write addr", {15'd0, log_a[0]}, 32'h01234);
      check("R6 write data", {24'd0, log_d[0]}, 32'h5A);
    end
  endtask

  task automatic t_mismatch();
    logic a;
    do_start(1'b0);
    send(8'hB2, a); check("R1 bad code nack", {31'd0, a}, 32'd0);
    send(8'h00, a); check("R1 later byte nack", {31'd0, a}, 32'd0);
    do_start(1'b0);
    send(8'hA4, a); check("R1 chip select nack", {31'd0, a}, 32'd0);
    do_start(1'b0);
    send(8'hA3, a); check("R12 read nack", {31'd0, a}, 32'd0);
    do_stop(1'b0, 1'b0);
    check("R1 no commit", {31'd0, busy_o}, 32'd0);
  endtask

  task automatic t_cross_page();
    logic a;
    logic [16:0] ea[6] = '{17'h10500, 17'h10501, 17'h1053C, 17'h1053D, 17'h1053E, 17'h1053F};
    logic [7:0]  ed[6] = '{8'hC4, 8'hC5, 8'hC0, 8'hC1, 8'hC2, 8'hC3};
    log_a.delete(); log_d.delete();
    setup(8'hAA, 8'h05, 8'h3C);
    check("R3 block bit load", {15'd0, ptr_o}, 32'h1053C);
    for (int k = 0; k < 6; k++) send(8'hC0 + 8'(k), a);
    check("R4 ptr wrap in page", {15'd0, ptr_o}, 32'h10502);
    do_stop(1'b0, 1'b0);
    wait_idle();
    check("R4 write count", log_a.size(), 32'd6);
    if (log_a.size() == 6) begin
      for (int k = 0; k < 6; k++) begin
        check("R6 order addr", {15'd0, log_a[k]}, {15'd0, ea[k]});
        check("R4 wrap data", {24'd0, log_d[k]}, {24'd0, ed[k]});
      end
    end
  endtask

  task automatic t_overflow();
    logic a;
    log_a.delete(); log_d.delete();
    setup(8'hA2, 8'h00, 8'h80);
    for (int k = 0; k < 66; k++) send(8'(k), a);
    check("R5 ack last", {31'd0, a}, 32'd1);
    do_stop(1'b0, 1'b0);
    wait_idle();
    check("R5 write count", log_a.size(), 32'd64);
    if (log_a.size() == 64) begin
      check("R5 slot0", {24'd0, log_d[0]}, 32'd64);
      check("R5 slot1", {24'd0, log_d[1]}, 32'd65);
      check("R5 slot2", {24'd0, log_d[2]}, 32'd2);
      check("R5 last addr", {15'd0, log_a[63]}, 32'h000BF);
    end
  endtask

  task automatic t_protect();
    logic a;
    log_a.delete(); log_d.delete();
    setup(8'hA2, 8'h00, 8'h10);
    send(8'h11, a); check("R7 data ack under wp", {31'd0, a}, 32'd1);
    send(8'h22, a);
    do_stop(1'b1, 1'b0);
    check("R7 no busy", {31'd0, busy_o}, 32'd0);
    repeat (70) @(negedge clk);
    check("R7 no writes", log_a.size(), 32'd0);
    wp_i = 1'b0;
    setup(8'hA2, 8'h00, 8'h20);
    send(8'h33, a);
    do_stop(1'b0, 1'b0);
    wp_i = 1'b1;
    wait_idle();
    wp_i = 1'b0;
    check("R7 late wp ignored", log_a.size(), 32'd1);
  endtask

  task automatic t_busy_poll();
    logic a;
    log_a.delete(); log_d.delete();
    setup(8'hA2, 8'h03, 8'h00);
    send(8'h44, a);
    do_stop(1'b0, 1'b0);
    do_start(1'b0);
    send(8'hA2, a); check("R8 poll nack", {31'd0, a}, 32'd0);
    do_stop(1'b0, 1'b0);
    wait_idle();
    check("R8 one write", log_a.size(), 32'd1);
    do_start(1'b0);
    send(8'hA2, a); check("R8 ack after busy", {31'd0, a}, 32'd1);
    do_stop(1'b0, 1'b0);
  endtask

  task automatic t_abort();
    logic a;
    log_a.delete(); log_d.delete();
    setup(8'hA2, 8'h00, 8'h40);
    send(8'h77, a);
    do_stop(1'b0, 1'b1);
    check("R9 no busy", {31'd0, busy_o}, 32'd0);
    repeat (70) @(negedge clk);
    check("R9 no writes", log_a.size(), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_byte_write();
    t_mismatch();
    t_cross_page();
    t_overflow();
    t_protect();
    t_busy_poll();
    t_abort();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule